// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block accepts interrupts for one processor from a space of 256 vectors. It keeps three 256-bit bitmaps: pending requests, vectors in service, and the trigger mode of each vector. It also keeps an 8-bit task priority and a 9-bit spurious register. Bit 8 of the spurious register is the software enable, and its low byte is the vector returned when no real vector can be given. A request names a vector and a trigger mode. The block derives a processor priority from the task priority and the highest vector in service. It raises `irq_out` while the top pending vector lies in a higher 16-vector class than that priority.

The processor acknowledges with a one-cycle `ack_req`. One cycle later the block answers on `ack_vec` with `ack_done`. It either moves the top pending vector into service or returns the spurious vector and leaves the bitmaps untouched. A one-cycle `eoi` retires the highest vector in service. Software reaches the registers through a word-indexed register window, where the register index is the address shifted right by four.

Top module: `vec_irq_arbiter`

## Requirements
- R1: The register window is read at index = `rd_addr >> 4`. Indexes 0x10..0x17 return the in-service words, 0x18..0x1F the trigger-mode words and 0x20..0x27 the request words. Word k bit i stands for vector 32k+i, and a higher vector number has higher priority.
- R2: A cycle with `set_req` high sets the request bit of `set_vec`. It sets that vector's trigger-mode bit when `set_level` is 1 and clears it when `set_level` is 0.
- R3: `irq_out` is high exactly when the enable (spurious register bit 8) is set, some request bit is set, and either the processor priority is zero or bits [7:4] of the top request exceed bits [7:4] of the processor priority.
- R4: `ack_req` is answered in the next cycle by `ack_done` with a value on `ack_vec`. The answer is the low byte of the spurious register, with no bitmap change, in three cases: the enable is clear, no request is pending, or the task priority is nonzero and the top request is less than or equal to it. Otherwise the top request bit moves from the request bitmap to the in-service bitmap and that vector is returned.
- R5: `eoi` clears the highest set in-service bit. When no in-service bit is set it changes nothing.
- R6: Index 0x0F is the spurious register: a write keeps bits [8:0], and it resets to 0x0FF. Index 0x08 is the task priority: a write keeps bits [7:0]. Writes to the bitmap indexes have no effect, and reads of unmapped indexes return 0.
- R7: The processor priority, read at index 0x0A, equals the task priority when the task priority class (bits [7:4]) is at least the class of the top in-service vector. Otherwise it equals the top in-service vector with bits [3:0] cleared. With nothing in service it equals the task priority.
- R8: Reset clears all three bitmaps and the task priority and deasserts `irq_out`.
- R9: In one cycle, acknowledge and end-of-interrupt both act on the state before the edge, and a set request is applied last. A set of the vector being acknowledged therefore leaves its request bit set, and an `eoi` issued with an acknowledge clears the previously highest in-service vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_req | input | 1 | Post a request for `set_vec` this cycle |
| set_vec | input | 8 | Vector of the posted request |
| set_level | input | 1 | 1 = level-triggered request, 0 = edge-triggered |
| ack_req | input | 1 | Processor acknowledge, one cycle |
| ack_vec | output | 8 | Vector returned for the last acknowledge |
| ack_done | output | 1 | `ack_vec` is valid this cycle |
| eoi | input | 1 | End of interrupt, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume that `ack_req` and `eoi` are one-cycle strobes. They also assume that `set_vec` is stable whenever `set_req` is high, and that reset is held across at least one clock edge. The stimulus drives every strobe for one cycle from tasks at the falling edge and releases it at the next falling edge, so each operation lands on exactly one rising edge. The sweeps cover every vector singly, every pair of in-service and pending classes, and every task priority value. The same-cycle combinations of R9 are driven on purpose, and no other overlap is driven.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int VEC_W     = 8;
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WSEL_W    = $clog2(NUM_WORDS);
  localparam int CLS_LSB   = 4;
  localparam int SVR_W     = VEC_W + 1;

  // register indexes (address >> 4)
  localparam int TPR_IDX  = 'h08;
  localparam int PPR_IDX  = 'h0A;
  localparam int SVR_IDX  = 'h0F;
  localparam int ISR_BASE = 'h10;
  localparam int TMR_BASE = 'h18;
  localparam int IRR_BASE = 'h20;

  typedef logic [VEC_W-1:0] vec_t;

  // processor priority from task priority and top in-service vector
  function automatic vec_t calc_ppr(input vec_t tpr, input logic isr_any, input vec_t isr_top);
    vec_t cls;
    cls = isr_any ? {isr_top[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}} : '0;
    if (tpr[VEC_W-1:CLS_LSB] >= cls[VEC_W-1:CLS_LSB]) return tpr;
    return cls;
  endfunction

  // a pending vector outranks the processor priority
  function automatic logic beats_ppr(input vec_t req_top, input vec_t ppr);
    return (ppr == '0) || (req_top[VEC_W-1:CLS_LSB] > ppr[VEC_W-1:CLS_LSB]);
  endfunction

  // acknowledge held off by the task priority
  function automatic logic tpr_blocks(input vec_t tpr, input vec_t req_top);
    return (tpr != '0) && (req_top <= tpr);
  endfunction
endpackage

// File: rtl/vec_top_finder.sv
module vec_top_finder
  import vec_irq_pkg::*;
#(
  parameter int N = NUM_VEC,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        top = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vec_reg_window.sv
module vec_reg_window
  import vec_irq_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]  idx,
  input  vec_t              tpr,
  input  vec_t              ppr,
  input  logic [SVR_W-1:0]  svr,
  input  logic [NUM_VEC-1:0] isr,
  input  logic [NUM_VEC-1:0] tmr,
  input  logic [NUM_VEC-1:0] irr,
  output logic [WORD_W-1:0] rd_data
);
  logic [IDX_W-1:0]  bank;
  logic [WSEL_W-1:0] word;

  assign bank = idx & ~IDX_W'(NUM_WORDS - 1);
  assign word = idx[WSEL_W-1:0];

  always_comb begin
    rd_data = '0;
    if (idx == IDX_W'(TPR_IDX))       rd_data = WORD_W'(tpr);
    else if (idx == IDX_W'(PPR_IDX))  rd_data = WORD_W'(ppr);
    else if (idx == IDX_W'(SVR_IDX))  rd_data = WORD_W'(svr);
    else if (bank == IDX_W'(ISR_BASE)) rd_data = isr[word*WORD_W +: WORD_W];
    else if (bank == IDX_W'(TMR_BASE)) rd_data = tmr[word*WORD_W +: WORD_W];
    else if (bank == IDX_W'(IRR_BASE)) rd_data = irr[word*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter
  import vec_irq_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_req,
  input  logic [VEC_W-1:0]  set_vec,
  input  logic              set_level,
  input  logic              ack_req,
  output logic [VEC_W-1:0]  ack_vec,
  output logic              ack_done,
  input  logic              eoi,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out
);
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);
  localparam logic [SVR_W-1:0]   SVR_RESET = SVR_W'('h0FF);

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
  vec_t               tpr_q;
  logic [SVR_W-1:0]   svr_q;
  vec_t               ack_vec_q;
  logic               ack_done_q;

  // named internal events
  logic               irr_any, isr_any;
  vec_t               irr_top, isr_top;
  vec_t               ppr;
  logic               sw_enable;
  logic               grant;
  logic               retire;
  logic [NUM_VEC-1:0] set_mask, grant_mask, retire_mask;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic               unused_low_bits;

  vec_top_finder #(.N(NUM_VEC)) u_irr_find (.bits(irr_q), .any(irr_any), .top(irr_top));
  vec_top_finder #(.N(NUM_VEC)) u_isr_find (.bits(isr_q), .any(isr_any), .top(isr_top));

  assign sw_enable   = svr_q[VEC_W];
  assign ppr         = calc_ppr(tpr_q, isr_any, isr_top);
  assign irq_out     = sw_enable && irr_any && beats_ppr(irr_top, ppr);
  assign grant       = ack_req && sw_enable && irr_any && !tpr_blocks(tpr_q, irr_top);
  assign retire      = eoi && isr_any;
  assign set_mask    = set_req ? (ONE << set_vec) : '0;
  assign grant_mask  = grant   ? (ONE << irr_top) : '0;
  assign retire_mask = retire  ? (ONE << isr_top) : '0;

  // acknowledge and eoi see the old state; the set lands last
  assign irr_d = (irr_q & ~grant_mask) | set_mask;
  assign isr_d = (isr_q & ~retire_mask) | grant_mask;
  assign tmr_d = set_level ? (tmr_q | set_mask) : (tmr_q & ~set_mask);

  assign wr_idx = wr_addr[ADDR_W-1:4];
  assign rd_idx = rd_addr[ADDR_W-1:4];
  assign unused_low_bits = ^{wr_addr[3:0], rd_addr[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q      <= '0;
      isr_q      <= '0;
      tmr_q      <= '0;
      tpr_q      <= '0;
      svr_q      <= SVR_RESET;
      ack_vec_q  <= '0;
      ack_done_q <= 1'b0;
    end else begin
      irr_q      <= irr_d;
      isr_q      <= isr_d;
      tmr_q      <= tmr_d;
      ack_done_q <= ack_req;
      if (ack_req) ack_vec_q <= grant ? irr_top : svr_q[VEC_W-1:0];
      if (wr_en && wr_idx == IDX_W'(TPR_IDX)) tpr_q <= wr_data[VEC_W-1:0];
      if (wr_en && wr_idx == IDX_W'(SVR_IDX)) svr_q <= wr_data[SVR_W-1:0];
    end
  end

  assign ack_vec  = ack_vec_q;
  assign ack_done = ack_done_q;

  vec_reg_window #(.IDX_W(IDX_W)) u_window (
    .idx(rd_idx), .tpr(tpr_q), .ppr(ppr), .svr(svr_q),
    .isr(isr_q), .tmr(tmr_q), .irr(irr_q), .rd_data(rd_data)
  );
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk
  import vec_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               set_req,
  input logic [VEC_W-1:0]   set_vec,
  input logic               set_level,
  input logic               ack_req,
  input logic               eoi,
  input logic               ack_done,
  input logic               irq_out,
  input logic               sw_enable,
  input logic [NUM_VEC-1:0] irr_bits,
  input logic [NUM_VEC-1:0] isr_bits,
  input logic [NUM_VEC-1:0] tmr_bits,
  input logic               isr_any,
  input logic [VEC_W-1:0]   isr_top,
  input logic [VEC_W-1:0]   ppr
);
  assert_irq_off_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_enable |-> !irq_out);

  assert_irq_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irr_bits != '0));

  assert_set_marks_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irr_bits[$past(set_vec)]);

  assert_trigger_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> (tmr_bits[$past(set_vec)] == $past(set_level)));

  assert_ack_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_done);

  assert_no_answer_unasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_done);

  assert_service_grows_by_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> ($countones(isr_bits) <= $countones($past(isr_bits))));

  assert_eoi_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack_req && isr_bits == '0) |=> (isr_bits == '0));

  assert_ppr_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr_any |-> (ppr[VEC_W-1:CLS_LSB] >= isr_top[VEC_W-1:CLS_LSB]));
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_vec(set_vec),
  .set_level(set_level), .ack_req(ack_req), .eoi(eoi), .ack_done(ack_done),
  .irq_out(irq_out), .sw_enable(sw_enable), .irr_bits(irr_q), .isr_bits(isr_q),
  .tmr_bits(tmr_q), .isr_any(isr_any), .isr_top(isr_top), .ppr(ppr)
);

// File: tb/vec_irq_arbiter_test.sv
module vec_irq_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_req = 0, set_level = 0, ack_req = 0, eoi = 0, wr_en = 0;
  logic [7:0]  set_vec = '0;
  logic [11:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  ack_vec;
  logic        ack_done, irq_out;
  logic [31:0] rd_data;
  int          total = 0, bad = 0;
  logic [255:0] tmr_m = '0;

  always #4 clk = ~clk;

  vec_irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .set_vec(set_vec), .set_level(set_level),
    .ack_req(ack_req), .ack_vec(ack_vec), .ack_done(ack_done), .eoi(eoi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic [7:0] v, input logic lv, input logic a, input logic e);
    set_req = s; set_vec = v; set_level = lv; ack_req = a; eoi = e;
    if (s) tmr_m[v] = lv;
    @(posedge clk); @(negedge clk);
    set_req = 0; ack_req = 0; eoi = 0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    wr_en = 1; wr_addr = {idx, 4'h0}; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] val);
    rd_addr = {idx, 4'h0};
    #1;
    val = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 / R6: reset state
    chk("R8 irq after reset", 32'(irq_out), 0);
    rd(8'h08, r); chk("R8 tpr reset", r, 0);
    rd(8'h0F, r); chk("R6 svr reset", r, 32'h0FF);
    for (int w = 0; w < 8; w++) begin
      rd(8'(8'h20 + w), r); chk("R8 irr reset", r, 0);
      rd(8'(8'h10 + w), r); chk("R8 isr reset", r, 0);
      rd(8'(8'h18 + w), r); chk("R8 tmr reset", r, 0);
    end

    // R6: register widths, read-only bitmaps, unmapped
    wr(8'h0F, 32'hFFFF_FFFF); rd(8'h0F, r); chk("R6 svr keeps 9 bits", r, 32'h1FF);
    wr(8'h08, 32'h1234_5678); rd(8'h08, r); chk("R6 tpr keeps 8 bits", r, 32'h78);
    wr(8'h08, 0);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, r); chk("R6 irr write ignored", r, 0);
    wr(8'h10, 32'hFFFF_FFFF); rd(8'h10, r); chk("R6 isr write ignored", r, 0);
    rd(8'h03, r); chk("R6 unmapped read", r, 0);
    wr(8'h0F, 32'h1E7);

    // R1 R2 R3 R4 R5 R7: every vector alone
    for (int v = 0; v < 256; v++) begin
      cyc(1, 8'(v), v[0], 0, 0);
      rd(8'(8'h20 + (v >> 5)), r); chk("R1 R2 irr word", r, 32'h1 << (v % 32));
      rd(8'(8'h18 + (v >> 5)), r); chk("R2 tmr word", r, tmr_m[(v >> 5) * 32 +: 32]);
      chk("R3 irq single", 32'(irq_out), 1);
      cyc(0, 0, 0, 1, 0);
      chk("R4 ack vector", 32'(ack_vec), 32'(v));
      chk("R4 ack_done", 32'(ack_done), 1);
      rd(8'(8'h10 + (v >> 5)), r); chk("R1 R4 isr word", r, 32'h1 << (v % 32));
      rd(8'(8'h20 + (v >> 5)), r); chk("R4 irr cleared", r, 0);
      chk("R3 irq idle", 32'(irq_out), 0);
      rd(8'h0A, r); chk("R7 ppr from isr", r, 32'((v / 16) * 16));
      cyc(0, 0, 0, 0, 1);
      rd(8'(8'h10 + (v >> 5)), r); chk("R5 eoi clears", r, 0);
    end

    // R3 R7: in-service class against pending class
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        cyc(1, 8'(i * 16 + 5), 0, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(1, 8'(j * 16 + 3), 1, 0, 0);
        chk("R3 class compare", 32'(irq_out), 32'((i == 0) || (j > i)));
        cyc(0, 0, 0, 1, 0);
        chk("R4 ack top", 32'(ack_vec), 32'(j * 16 + 3));
        cyc(0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 1);
      end
    end
    rd(8'h10 + 8'h4, r); chk("R5 isr empty after pairs", r, 0);

    // R3 R4 R7: every task priority against pending 0x80
    for (int t = 0; t < 256; t++) begin
      wr(8'h08, 32'(t));
      cyc(1, 8'h80, 0, 0, 0);
      rd(8'h0A, r); chk("R7 ppr equals tpr", r, 32'(t));
      chk("R3 tpr gate", 32'(irq_out), 32'((t == 0) || (8 > (t / 16))));
      cyc(0, 0, 0, 1, 0);
      if (t != 0 && t >= 8'h80) begin
        chk("R4 spurious", 32'(ack_vec), 32'hE7);
        rd(8'h24, r); chk("R4 spurious keeps irr", r, 1);
        rd(8'h14, r); chk("R4 spurious keeps isr", r, 0);
      end else begin
        chk("R4 granted", 32'(ack_vec), 32'h80);
        cyc(0, 0, 0, 0, 1);
      end
    end
    wr(8'h08, 0);
    cyc(0, 0, 0, 1, 0); chk("R4 release", 32'(ack_vec), 32'h80);
    cyc(0, 0, 0, 0, 1);

    // R7: task priority class above in-service class
    cyc(1, 8'h45, 0, 0, 0); cyc(0, 0, 0, 1, 0);
    wr(8'h08, 32'h3C); rd(8'h0A, r); chk("R7 isr class wins", r, 32'h40);
    wr(8'h08, 32'h4C); rd(8'h0A, r); chk("R7 tpr wins same class", r, 32'h4C);
    wr(8'h08, 0); cyc(0, 0, 0, 0, 1);

    // R3 R4: software disabled
    wr(8'h0F, 32'h0E7);
    cyc(1, 8'h40, 0, 0, 0);
    chk("R3 disabled irq", 32'(irq_out), 0);
    cyc(0, 0, 0, 1, 0);
    chk("R4 disabled spurious", 32'(ack_vec), 32'hE7);
    rd(8'h22, r); chk("R4 disabled keeps irr", r, 1);
    wr(8'h0F, 32'h1E7);
    cyc(0, 0, 0, 1, 0); chk("R4 reenabled", 32'(ack_vec), 32'h40);
    cyc(0, 0, 0, 0, 1);

    // R4: no request pending
    cyc(0, 0, 0, 1, 0); chk("R4 empty spurious", 32'(ack_vec), 32'hE7);

    // R5: eoi with nothing in service
    cyc(1, 8'h21, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    rd(8'h11, r); chk("R5 idle eoi isr", r, 0);
    rd(8'h21, r); chk("R5 idle eoi irr", r, 32'h2);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1);

    // R9: set of the acknowledged vector in the same cycle
    cyc(1, 8'h90, 0, 0, 0);
    cyc(1, 8'h90, 0, 1, 0);
    chk("R9 ack vector", 32'(ack_vec), 32'h90);
    rd(8'h24, r); chk("R9 irr kept", r, 32'h1_0000);
    rd(8'h14, r); chk("R9 isr set", r, 32'h1_0000);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1);

    // R9: eoi together with ack
    cyc(1, 8'h30, 0, 0, 0); cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h50, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R9 ack with eoi", 32'(ack_vec), 32'h50);
    rd(8'h11, r); chk("R9 old isr retired", r, 0);
    rd(8'h12, r); chk("R9 new isr held", r, 32'h1_0000);

    // R8: reset mid-run
    cyc(1, 8'hC3, 1, 0, 0);
    wr(8'h08, 32'h22);
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    rd(8'h26, r); chk("R8 irr cleared", r, 0);
    rd(8'h12, r); chk("R8 isr cleared", r, 0);
    rd(8'h1E, r); chk("R8 tmr cleared", r, 0);
    rd(8'h08, r); chk("R8 tpr cleared", r, 0);
    chk("R8 irq cleared", 32'(irq_out), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule